// File: doc/BRIEF.md
# CAN Frame Timestamp Timer

This block keeps network time for a CAN controller. A free-running counter advances by one on every bit-time tick that the protocol engine raises. The engine raises that tick for each bit sent or received during a frame, and at the programmed bit rate while the bus is idle. The counter stops advancing while the controller sits in any of its four hold modes: disabled, doze, stop or debug freeze. When synchronization is enabled, a sync-frame strobe from the receive path clears the counter so that the nodes on the network share a common time base.

The engine pulses a strobe when a frame's identifier begins. On that pulse the block copies the counter value into a pending register. The pending value is not yet visible on the timestamp output. It is committed there only when the frame has been fully moved into its message buffer. A one-cycle valid pulse comes with the commit so that storage logic can write the timestamp next to the frame.

Top module: `can_ts_timer`

## Requirements
- R1: A synchronous active-high reset sets the count, the pending sample and the committed timestamp to zero and holds the valid output low. A commit made after reset with no sample taken yields zero.
- R2: With no hold mode active and no sync clear, a bit tick raises the count by exactly one, visible the cycle after the tick.
- R3: In a cycle without a bit tick and without a sync clear, the count keeps its value.
- R4: The count wraps from its maximum value (0xFFFF at the default 16-bit width) to zero on the next tick and raises no flag.
- R5: While any one of the disable, doze, stop or freeze inputs is high, ticks have no effect and the count keeps its value.
- R6: When the sync-enable input is high, a sync-frame strobe makes the count read zero the next cycle. This holds even if a tick or a hold mode is present in the same cycle.
- R7: A sync-frame strobe while sync-enable is low has no effect. A tick in the same cycle increments the count as usual.
- R8: An identifier-start strobe samples the count present in that cycle, which is the value before that cycle's tick takes effect.
- R9: The timestamp output changes only in the cycle after a move-in-complete strobe. At that point it shows the pending sample. Samples taken earlier leave it unchanged.
- R10: The valid output is high for exactly the one cycle after each move-in-complete strobe and low otherwise.
- R11: A second identifier-start strobe before move-in completes replaces the pending sample. Only the newest sample is committed.
- R12: If identifier-start and move-in-complete fall in the same cycle, the commit uses the previously pending sample. The new sample stays pending for the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bit_tick_i | input | 1 | One-cycle pulse per CAN bit time |
| id_start_i | input | 1 | Identifier field has begun on the bus |
| movein_done_i | input | 1 | Frame move-in to the message buffer finished |
| mode_disable_i | input | 1 | Module disabled; count held |
| mode_doze_i | input | 1 | Doze mode; count held |
| mode_stop_i | input | 1 | Stop mode; count held |
| mode_freeze_i | input | 1 | Debug freeze; count held |
| sync_en_i | input | 1 | Allows sync frames to clear the count |
| sync_frame_i | input | 1 | A sync frame has been received |
| count_o | output | CNT_W | Live counter value |
| stamp_o | output | CNT_W | Committed frame timestamp |
| stamp_valid_o | output | 1 | One-cycle pulse when stamp_o is updated |

## Verification
Every result is registered once. The count, the timestamp and the valid pulse all reflect a strobe or tick in the first cycle after the clock edge that sampled it. A sample taken by the identifier strobe shows up only one cycle after a later move-in strobe. The bench drives inputs just after an edge and compares the outputs one time unit after the next edge against a model that it advances from the requirements on the same edge. Every check therefore lands exactly one register stage after its cause. A full sweep of all 65,536 count values confirms the increment and the wrap. Directed sequences cover the hold modes, sync, overwrite and same-cycle cases.

// File: rtl/can_ts_pkg.sv
package can_ts_pkg;

   // number of low-power / debug modes that hold the counter
   localparam int unsigned HOLD_MODES = 4;

   // next-state selection of the free-running counter
   typedef enum logic [1:0] {
      CNT_KEEP  = 2'd0,
      CNT_STEP  = 2'd1,
      CNT_CLEAR = 2'd2
   } cnt_op_e;

endpackage

// File: rtl/ts_hold_gate.sv
module ts_hold_gate #(
   parameter int unsigned N_HOLD = 4
) (
   input  logic [N_HOLD-1:0] hold_req_i,
   output logic              frozen_o
);

   logic [N_HOLD:0] chain;

   assign chain[0] = 1'b0;

   // OR chain across every hold request
   for (genvar g = 0; g < N_HOLD; g++) begin : g_hold
      assign chain[g+1] = chain[g] | hold_req_i[g];
   end

   assign frozen_o = chain[N_HOLD];

endmodule

// File: rtl/ts_free_counter.sv
module ts_free_counter
   import can_ts_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic             frozen_i,
   input  logic             sync_en_i,
   input  logic             sync_frame_i,
   output logic [CNT_W-1:0] count_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   cnt_op_e          op;
   logic [CNT_W-1:0] count_q;

   // sync clear outranks both the tick and the hold modes
   always_comb begin
      op = CNT_KEEP;
      if (sync_en_i && sync_frame_i) begin
         op = CNT_CLEAR;
      end else if (tick_i && !frozen_i) begin
         op = CNT_STEP;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         count_q <= '0;
      end else begin
         case (op)
            CNT_CLEAR: count_q <= '0;
            CNT_STEP:  count_q <= count_q + ONE;   // natural wrap
            default:   count_q <= count_q;
         endcase
      end
   end

   assign count_o = count_q;

endmodule

// File: rtl/ts_capture.sv
module ts_capture #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic             sample_i,
   input  logic             commit_i,
   output logic [CNT_W-1:0] stamp_o,
   output logic             valid_o
);

   logic [CNT_W-1:0] pend_q;
   logic [CNT_W-1:0] stamp_q;
   logic             valid_q;

   // pending sample: latest identifier start wins
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_q <= '0;
      end else if (sample_i) begin
         pend_q <= count_i;
      end
   end

   // commit reads the pending value from before this edge
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         stamp_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= commit_i;
         if (commit_i) begin
            stamp_q <= pend_q;
         end
      end
   end

   assign stamp_o = stamp_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/can_ts_timer.sv
module can_ts_timer
   import can_ts_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             bit_tick_i,
   input  logic             id_start_i,
   input  logic             movein_done_i,
   input  logic             mode_disable_i,
   input  logic             mode_doze_i,
   input  logic             mode_stop_i,
   input  logic             mode_freeze_i,
   input  logic             sync_en_i,
   input  logic             sync_frame_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] stamp_o,
   output logic             stamp_valid_o
);

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
      $error("can_ts_timer: CNT_W must lie in 2..64");
   end

   logic [HOLD_MODES-1:0] hold_vec;
   logic                  frozen;
   logic [CNT_W-1:0]      count;

   assign hold_vec = {mode_freeze_i, mode_stop_i, mode_doze_i, mode_disable_i};

   ts_hold_gate #(
      .N_HOLD (HOLD_MODES)
   ) u_gate (
      .hold_req_i (hold_vec),
      .frozen_o   (frozen)
   );

   ts_free_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .tick_i       (bit_tick_i),
      .frozen_i     (frozen),
      .sync_en_i    (sync_en_i),
      .sync_frame_i (sync_frame_i),
      .count_o      (count)
   );

   ts_capture #(
      .CNT_W (CNT_W)
   ) u_cap (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .count_i  (count),
      .sample_i (id_start_i),
      .commit_i (movein_done_i),
      .stamp_o  (stamp_o),
      .valid_o  (stamp_valid_o)
   );

   assign count_o = count;

endmodule

// File: rtl/can_ts_chk.sv
module can_ts_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             bit_tick_i,
   input logic             movein_done_i,
   input logic             mode_disable_i,
   input logic             mode_doze_i,
   input logic             mode_stop_i,
   input logic             mode_freeze_i,
   input logic             sync_en_i,
   input logic             sync_frame_i,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] stamp_o,
   input logic             stamp_valid_o
);

   logic held;
   logic clr;

   assign held = mode_disable_i | mode_doze_i | mode_stop_i | mode_freeze_i;
   assign clr  = sync_en_i & sync_frame_i;

   AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
      (bit_tick_i && !held && !clr) |=> count_o == CNT_W'($past(count_o) + 1'b1)); // R2

   AST_IDLE_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (!bit_tick_i && !clr) |=> $stable(count_o)); // R3

   AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
      (held && !clr) |=> $stable(count_o)); // R5

   AST_SYNC_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      clr |=> count_o == '0); // R6

   AST_STAMP_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      !movein_done_i |=> $stable(stamp_o)); // R9

   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      movein_done_i |=> stamp_valid_o); // R10

   AST_VALID_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
      !movein_done_i |=> !stamp_valid_o); // R10

endmodule

bind can_ts_timer can_ts_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk_i          (clk_i),
   .rst_i          (rst_i),
   .bit_tick_i     (bit_tick_i),
   .movein_done_i  (movein_done_i),
   .mode_disable_i (mode_disable_i),
   .mode_doze_i    (mode_doze_i),
   .mode_stop_i    (mode_stop_i),
   .mode_freeze_i  (mode_freeze_i),
   .sync_en_i      (sync_en_i),
   .sync_frame_i   (sync_frame_i),
   .count_o        (count_o),
   .stamp_o        (stamp_o),
   .stamp_valid_o  (stamp_valid_o)
);

// File: tb/sim_can_ts_timer.sv
`timescale 1ns/1ps
module sim_can_ts_timer;

   localparam int unsigned W = 16;
   localparam int unsigned MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         tick = 1'b0, ids = 1'b0, mvi = 1'b0;
   logic         m_dis = 1'b0, m_doz = 1'b0, m_stp = 1'b0, m_frz = 1'b0;
   logic         s_en = 1'b0, s_frm = 1'b0;
   logic [W-1:0] cnt, stamp;
   logic         vld;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // bench model, built from the requirements
   int e_cnt = 0, e_pend = 0, e_stamp = 0;
   int e_vld = 0;

   always #2.5 clk = ~clk;

   can_ts_timer #(.CNT_W(W)) u0 (
      .clk_i(clk), .rst_i(rst), .bit_tick_i(tick), .id_start_i(ids),
      .movein_done_i(mvi), .mode_disable_i(m_dis), .mode_doze_i(m_doz),
      .mode_stop_i(m_stp), .mode_freeze_i(m_frz), .sync_en_i(s_en),
      .sync_frame_i(s_frm), .count_o(cnt), .stamp_o(stamp), .stamp_valid_o(vld)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one clock: apply strobes, advance model on the edge, sample 1 ns later
   task automatic cyc(input logic t, input logic s, input logic m, input logic sy);
      int old_cnt;
      tick = t; ids = s; mvi = m; s_frm = sy;
      @(posedge clk);
      old_cnt = e_cnt;
      if (s_en && sy) e_cnt = 0;
      else if (t && !(m_dis || m_doz || m_stp || m_frz)) e_cnt = (e_cnt + 1) % (MAXV + 1);
      e_vld = m ? 1 : 0;
      if (m) e_stamp = e_pend;
      if (s) e_pend = old_cnt;
      #1;
      tick = 1'b0; ids = 1'b0; mvi = 1'b0; s_frm = 1'b0;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            finish_run();
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R1 reset state
      chk("R1 count", cnt, 0);
      chk("R1 stamp", stamp, 0);
      chk("R1 valid", vld, 0);
      cyc(0, 0, 1, 0);
      chk("R1 commit without sample", stamp, 0);
      chk("R10 valid after move-in", vld, 1);
      cyc(0, 0, 0, 0);
      chk("R10 valid drops", vld, 0);

      // R2/R4 sweep over every count value, ending on the wrap
      for (int i = 1; i <= MAXV + 1; i++) begin
         cyc(1, 0, 0, 0);
         chk("R2 step", cnt, i % (MAXV + 1));
         if (i == MAXV) chk("R4 reaches max", cnt, MAXV);
      end
      chk("R4 wrapped", cnt, 0);

      // R3 no tick
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
      chk("R3 hold without tick", cnt, 0);

      // R5 each hold mode alone
      cyc(1, 0, 0, 0);
      for (int k = 0; k < 4; k++) begin
         m_dis = (k == 0); m_doz = (k == 1); m_stp = (k == 2); m_frz = (k == 3);
         for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
         chk("R5 held by mode", cnt, 1);
         m_dis = 0; m_doz = 0; m_stp = 0; m_frz = 0;
      end
      cyc(1, 0, 0, 0);
      chk("R5 resumes", cnt, 2);

      // R6 sync clear wins over tick, and over a hold mode
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
      s_en = 1'b1;
      cyc(1, 0, 0, 1);
      chk("R6 sync with tick", cnt, 0);
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      m_frz = 1'b1;
      cyc(1, 0, 0, 1);
      chk("R6 sync under freeze", cnt, 0);
      m_frz = 1'b0;
      // R7 sync ignored when disabled
      s_en = 1'b0;
      cyc(1, 0, 0, 1);
      chk("R7 sync disabled", cnt, 1);

      // R8/R9/R10 sample with tick in same cycle, commit later
      for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0);
      chk("R8 before sample", cnt, 10);
      cyc(1, 1, 0, 0);
      chk("R8 count moved on", cnt, 11);
      for (int i = 0; i < 3; i++) begin
         cyc(1, 0, 0, 0);
         chk("R9 stamp untouched before move-in", stamp, 0);
      end
      cyc(0, 0, 1, 0);
      chk("R8 sampled pre-tick value", stamp, 10);
      chk("R10 pulse", vld, 1);
      cyc(0, 0, 0, 0);
      chk("R10 one cycle", vld, 0);
      chk("R9 stamp kept", stamp, 10);

      // R11 newer sample replaces pending one
      cyc(0, 1, 0, 0);
      cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
      cyc(0, 1, 0, 0);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 1, 0);
      chk("R11 latest sample", stamp, 16);

      // R12 sample and commit together
      cyc(0, 1, 1, 0);
      chk("R12 commits previous", stamp, 16);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 1, 0);
      chk("R12 new sample kept", stamp, 17);

      // model agreement
      chk("R2 model count", cnt, e_cnt);
      chk("R9 model stamp", stamp, e_stamp);
      chk("R10 model valid", vld, e_vld);
      finish_run();
   end

endmodule